// File: doc/BRIEF.md
# Timing Message Request-Reply Engine

This block runs the timing exchange between a node and its upstream reference over one serial line in each direction. A node that needs time asks for it: in requester mode a start pulse sends a short request frame, and the block then waits for the answer. A node that holds the reference count runs in responder mode. When a request arrives it puts its live down-counter value straight onto the line. The value is taken in one fixed cycle and is not stored in a buffer on the way.

When the requester receives the reply, it shifts the 16-bit count in. It then gives the local timebase a one-cycle load strobe together with the value. The path runs from the responder's sampling edge to the requester's strobe, and every stage on it is a fixed number of cycles. The total delay is therefore a known constant, and the timebase can add it back. The line runs at half the system clock rate, so every bit is held for two clock cycles. The line rests at 0 between frames.

Top module: `timing_xchg_engine`

## Requirements
- R1: After reset, txLine, loadStrobe and timeoutFlag are all 0.
- R2: A frame is a start bit of value 1, then a 2-bit type code sent MSB first, where 01 means request and 10 means reply. A reply frame then carries a 16-bit payload, MSB first. Every bit is held for exactly two clock cycles. In requester mode with the engine idle, a startReq pulse sends the request frame 1,0,1 from the cycle after the pulse, and the line then drops back to 0.
- R3: In responder mode, the reply frame starts on txLine seven cycles after the first cycle of the request's start bit on rxLine. That is two cycles after the request's last line cycle.
- R4: The reply payload is the liveCount value present in the cycle after the end of the request is detected. That is the cycle just before the reply's start bit appears.
- R5: In requester mode, while waiting for an answer, a received reply raises loadStrobe for exactly one cycle, with loadValue equal to the payload. The strobe comes in the cycle right after the last payload bit. A reply that arrives while the engine is not waiting produces no strobe.
- R6: Two engines connected back to back have a fixed latency. The requester's loadStrobe comes 46 cycles after the cycle in which startReq is sampled. The loaded value equals the responder's down-counter value in the strobe cycle plus 39.
- R7: If no reply frame starts within 64 bit times (128 cycles) after the request has been sent, the requester returns to idle and sets timeoutFlag. The next startReq clears the flag and sends a new request.
- R8: A frame with type code 00 or 11 is dropped. It produces no strobe and no reply, and the receiver at once hunts for the next start bit, so a valid reply that follows is still accepted.
- R9: In responder mode, startReq has no effect on txLine, and a received reply produces no strobe.
- R10: In requester mode, a received request frame does not cause a reply on txLine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; a line bit lasts two periods |
| rstN | input | 1 | Active-low synchronous reset |
| modeResponder | input | 1 | 1 = answer requests, 0 = issue requests |
| startReq | input | 1 | One-cycle pulse that starts a request (requester mode) |
| liveCount | input | 16 | Live down-counter value from the local timebase |
| rxLine | input | 1 | Serial receive line, idle 0 |
| txLine | output | 1 | Serial transmit line, idle 0 |
| loadStrobe | output | 1 | One-cycle strobe that loads loadValue into the timebase |
| loadValue | output | 16 | Count received in the last reply |
| timeoutFlag | output | 1 | Set when a request got no answer; cleared by the next start |

## Verification
The assertions assume that rxLine is synchronous to clk and holds each bit for two whole cycles. They also assume that modeResponder changes only while the engine is idle, and that startReq is a single-cycle pulse. The bench drives every frame from negedge-aligned tasks that keep each level for exactly two cycles. Mode changes and start pulses come only after earlier exchanges have finished or timed out. Between frames the line is held at 0, so no start bit is ever seen in the middle of a bit.

// File: rtl/timing_xchg_pkg.sv
package timing_xchg_pkg;

  localparam logic [1:0] TYPE_REQUEST = 2'b01;
  localparam logic [1:0] TYPE_REPLY   = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadReply;
  } txCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic txBusy;
    logic rxBusy;
    logic rxReqDone;
    logic rxReplyDone;
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND_REQ,
    ST_WAIT,
    ST_SEND_REPLY
  } xchgState_t;

endpackage

// File: rtl/timing_xchg_dp.sv
module timing_xchg_dp
  import timing_xchg_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  txCtrl_t            ctrl,
  input  logic [COUNT_W-1:0] liveCount,
  input  logic               rxLine,
  output logic               txLine,
  output dpStat_t            stat,
  output logic [COUNT_W-1:0] rxValue
);

  localparam int FRAME_W = 3 + COUNT_W;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] REQ_BITS  = IDX_W'(3);
  localparam logic [IDX_W-1:0] FULL_BITS = IDX_W'(FRAME_W);
  localparam logic [IDX_W-1:0] TYPE_IDX  = IDX_W'(2);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W - 1);

  // ---------------- transmitter ----------------
  logic [FRAME_W-1:0] txShift;
  logic [IDX_W-1:0]   txBitsLeft;
  logic               txActive;
  logic               txHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '0;
      txBitsLeft <= '0;
      txActive   <= 1'b0;
      txHalf     <= 1'b0;
    end else if (ctrl.loadReq) begin
      txShift    <= {1'b1, TYPE_REQUEST, {COUNT_W{1'b0}}};
      txBitsLeft <= REQ_BITS;
      txActive   <= 1'b1;
      txHalf     <= 1'b0;
    end else if (ctrl.loadReply) begin
      // live count taken in this very cycle, no holding register
      txShift    <= {1'b1, TYPE_REPLY, liveCount};
      txBitsLeft <= FULL_BITS;
      txActive   <= 1'b1;
      txHalf     <= 1'b0;
    end else if (txActive) begin
      txHalf <= ~txHalf;
      if (txHalf) begin
        txShift    <= {txShift[FRAME_W-2:0], 1'b0};
        txBitsLeft <= txBitsLeft - 1'b1;
        if (txBitsLeft == IDX_W'(1)) txActive <= 1'b0;
      end
    end
  end

  assign txLine = txActive & txShift[FRAME_W-1];

  // ---------------- receiver ----------------
  logic               rxActive;
  logic               rxPhase;
  logic [IDX_W-1:0]   rxIdx;
  logic [COUNT_W-1:0] rxShift;
  logic               rxReqDone;
  logic               rxReplyDone;
  logic [1:0]         rxType;

  assign rxType = {rxShift[0], rxLine};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive    <= 1'b0;
      rxPhase     <= 1'b0;
      rxIdx       <= '0;
      rxShift     <= '0;
      rxValue     <= '0;
      rxReqDone   <= 1'b0;
      rxReplyDone <= 1'b0;
    end else begin
      rxReqDone   <= 1'b0;
      rxReplyDone <= 1'b0;
      if (!rxActive) begin
        if (rxLine) begin
          rxActive <= 1'b1;
          rxPhase  <= 1'b1;
          rxIdx    <= '0;
        end
      end else begin
        rxPhase <= ~rxPhase;
        if (rxPhase) begin
          if (rxIdx == '0) begin
            // confirm start bit in its second half
            if (!rxLine) rxActive <= 1'b0;
            rxIdx <= rxIdx + 1'b1;
          end else begin
            rxShift <= {rxShift[COUNT_W-2:0], rxLine};
            rxIdx   <= rxIdx + 1'b1;
            if (rxIdx == TYPE_IDX) begin
              if (rxType == TYPE_REQUEST) begin
                rxReqDone <= 1'b1;
                rxActive  <= 1'b0;
              end else if (rxType != TYPE_REPLY) begin
                rxActive <= 1'b0;
              end
            end else if (rxIdx == LAST_IDX) begin
              rxValue     <= {rxShift[COUNT_W-2:0], rxLine};
              rxReplyDone <= 1'b1;
              rxActive    <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign stat.txBusy      = txActive;
  assign stat.rxBusy      = rxActive;
  assign stat.rxReqDone   = rxReqDone;
  assign stat.rxReplyDone = rxReplyDone;

  // ---------------- assertions ----------------
  assert_one_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadReq, ctrl.loadReply}));

  assert_bit_two_cycles_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txLine) |=> txLine);

  assert_load_when_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadReq || ctrl.loadReply) |-> !txActive);

  assert_frame_kind_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxReqDone, rxReplyDone}));

endmodule

// File: rtl/timing_xchg_ctrl.sv
module timing_xchg_ctrl
  import timing_xchg_pkg::*;
#(
  parameter int TIMEOUT_BITS = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeResponder,
  input  logic    startReq,
  input  dpStat_t stat,
  output txCtrl_t ctrl,
  output logic    loadStrobe,
  output logic    timeoutFlag
);

  localparam int TIMEOUT_CYC = 2 * TIMEOUT_BITS;
  localparam int TMR_W       = $clog2(TIMEOUT_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  xchgState_t       state, nextState;
  logic [TMR_W-1:0] waitTimer;
  logic             timeoutHit;

  always_comb begin
    ctrl       = '0;
    loadStrobe = 1'b0;
    timeoutHit = 1'b0;
    nextState  = state;
    unique case (state)
      ST_IDLE: begin
        if (!modeResponder && startReq) begin
          ctrl.loadReq = 1'b1;
          nextState    = ST_SEND_REQ;
        end else if (modeResponder && stat.rxReqDone) begin
          ctrl.loadReply = 1'b1;
          nextState      = ST_SEND_REPLY;
        end
      end
      ST_SEND_REQ: begin
        if (!stat.txBusy) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (stat.rxReplyDone) begin
          loadStrobe = 1'b1;
          nextState  = ST_IDLE;
        end else if (!stat.rxBusy && waitTimer == TMR_LAST) begin
          timeoutHit = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      ST_SEND_REPLY: begin
        if (!stat.txBusy) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      waitTimer   <= '0;
      timeoutFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state != ST_WAIT)   waitTimer <= '0;
      else if (!stat.rxBusy)  waitTimer <= waitTimer + 1'b1;
      if (ctrl.loadReq)       timeoutFlag <= 1'b0;
      else if (timeoutHit)    timeoutFlag <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  assert_timeout_from_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(state) == ST_WAIT);

  assert_responder_no_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeResponder && state == ST_IDLE) |=> state != ST_SEND_REQ);

endmodule

// File: rtl/timing_xchg_engine.sv
module timing_xchg_engine
  import timing_xchg_pkg::*;
#(
  parameter int COUNT_W      = 16,
  parameter int TIMEOUT_BITS = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeResponder,
  input  logic               startReq,
  input  logic [COUNT_W-1:0] liveCount,
  input  logic               rxLine,
  output logic               txLine,
  output logic               loadStrobe,
  output logic [COUNT_W-1:0] loadValue,
  output logic               timeoutFlag
);

  txCtrl_t ctrl;
  dpStat_t stat;

  timing_xchg_ctrl #(
    .TIMEOUT_BITS(TIMEOUT_BITS)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeResponder(modeResponder),
    .startReq     (startReq),
    .stat         (stat),
    .ctrl         (ctrl),
    .loadStrobe   (loadStrobe),
    .timeoutFlag  (timeoutFlag)
  );

  timing_xchg_dp #(
    .COUNT_W(COUNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .liveCount(liveCount),
    .rxLine   (rxLine),
    .txLine   (txLine),
    .stat     (stat),
    .rxValue  (loadValue)
  );

endmodule

// File: tb/tb_timing_xchg_engine.sv
module tb_timing_xchg_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeResponder = 1'b0;
  logic        startReq = 1'b0;
  logic        benchLine = 1'b0;
  logic        useBench = 1'b1;
  logic [15:0] liveCnt = 16'hC35A;
  int          cycleNo = 0;

  logic        dutTx, peerTx, dutRx;
  logic        loadStrobe, timeoutFlag;
  logic [15:0] loadValue;
  logic        peerStrobe, peerTimeout;
  logic [15:0] peerValue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          strobeCount = 0;
  int          strobeCycle = 0;
  logic [15:0] strobeVal = '0;
  logic [15:0] strobeLive = '0;

  always #2 clk = ~clk;

  assign dutRx = useBench ? benchLine : peerTx;

  timing_xchg_engine dut (
    .clk(clk), .rstN(rstN), .modeResponder(modeResponder), .startReq(startReq),
    .liveCount(liveCnt), .rxLine(dutRx), .txLine(dutTx),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .timeoutFlag(timeoutFlag));

  timing_xchg_engine peer (
    .clk(clk), .rstN(rstN), .modeResponder(1'b1), .startReq(1'b0),
    .liveCount(liveCnt), .rxLine(dutTx), .txLine(peerTx),
    .loadStrobe(peerStrobe), .loadValue(peerValue), .timeoutFlag(peerTimeout));

  always @(posedge clk) begin
    cycleNo <= cycleNo + 1;
    liveCnt <= liveCnt - 16'd1;
  end

  always @(negedge clk) begin
    if (loadStrobe) begin
      strobeCount = strobeCount + 1;
      strobeCycle = cycleNo;
      strobeVal   = loadValue;
      strobeLive  = liveCnt;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive n bits (MSB first) from f, two cycles each, starting at current negedge
  task automatic sendFrame(input logic [18:0] f, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      benchLine = f[i];
      repeat (2) @(negedge clk);
    end
    benchLine = 1'b0;
  endtask

  task automatic quietTx(input int n, input string req);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen |= dutTx;
    end
    check(!seen, req, 32'(seen), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!dutTx && !loadStrobe && !timeoutFlag, "R1",
          {29'd0, dutTx, loadStrobe, timeoutFlag}, 0);
  endtask

  task automatic testRequestFrame();
    logic [6:0] got;
    useBench = 1'b1; modeResponder = 1'b0;
    @(negedge clk);
    startReq = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      startReq = 1'b0;
      got[6-i] = dutTx;
    end
    check(got == 7'b1100110, "R2 request frame", 32'(got), 32'(7'b1100110));
    repeat (150) @(negedge clk);
  endtask

  task automatic testResponder();
    logic [15:0] expPay;
    logic [18:0] got;
    logic        halfErr = 1'b0;
    int          n0;
    useBench = 1'b1; modeResponder = 1'b1;
    @(negedge clk);
    n0 = cycleNo;
    sendFrame(19'b101, 3);
    expPay = liveCnt;                    // value held until edge n0+7
    @(negedge clk);
    check(dutTx == 1'b1 && cycleNo == n0 + 7, "R3 reply start", 32'(dutTx), 1);
    for (int i = 0; i < 19; i++) begin
      got[18-i] = dutTx;
      @(negedge clk);
      if (dutTx != got[18-i]) halfErr = 1'b1;
      @(negedge clk);
    end
    check(got[18:16] == 3'b110, "R2 reply header", 32'(got[18:16]), 32'(3'b110));
    check(got[15:0] == expPay, "R4 reply payload", 32'(got[15:0]), 32'(expPay));
    check(!halfErr && !dutTx, "R2 bit hold and idle", {30'd0, halfErr, dutTx}, 0);
    repeat (10) @(negedge clk);
    modeResponder = 1'b0;
  endtask

  task automatic testEndToEnd();
    int m0, c0;
    useBench = 1'b0; modeResponder = 1'b0;
    c0 = strobeCount;
    @(negedge clk);
    m0 = cycleNo;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < 100 && strobeCount == c0; i++) @(negedge clk);
    check(strobeCount == c0 + 1, "R6 strobe seen", 32'(strobeCount - c0), 1);
    check(strobeCycle == m0 + 46, "R6 latency", 32'(strobeCycle - m0), 46);
    check(strobeVal == strobeLive + 16'd39, "R6 compensated value",
          32'(strobeVal), 32'(strobeLive + 16'd39));
    check(!loadStrobe, "R5 single cycle strobe", 32'(loadStrobe), 0);
    repeat (10) @(negedge clk);
    useBench = 1'b1;
  endtask

  task automatic testTimeout();
    int m0, n0, c0;
    logic [15:0] val = 16'hA5C3;
    useBench = 1'b1; modeResponder = 1'b0;
    @(negedge clk);
    m0 = cycleNo;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (128) @(negedge clk);
    check(!timeoutFlag, "R7 no early timeout", 32'(timeoutFlag), 0);
    repeat (10) @(negedge clk);
    check(timeoutFlag, "R7 timeout raised", 32'(timeoutFlag), 1);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(!timeoutFlag && dutTx, "R7 restart clears flag", {30'd0, timeoutFlag, dutTx}, 1);
    repeat (9) @(negedge clk);
    c0 = strobeCount;
    n0 = cycleNo;
    sendFrame({1'b1, 2'b10, val}, 19);
    repeat (4) @(negedge clk);
    check(strobeCount == c0 + 1 && strobeVal == val, "R5 reply loaded",
          32'(strobeVal), 32'(val));
    check(strobeCycle == n0 + 38, "R5 strobe timing", 32'(strobeCycle - n0), 38);
    if (m0 < 0) check(0, "R7", 0, 0);
  endtask

  task automatic testBadType();
    int c0;
    logic [15:0] val = 16'h0F81;
    useBench = 1'b1; modeResponder = 1'b0;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (9) @(negedge clk);
    c0 = strobeCount;
    sendFrame(19'b111, 3);
    repeat (2) @(negedge clk);
    sendFrame(19'b100, 3);
    repeat (2) @(negedge clk);
    check(strobeCount == c0, "R8 bad types dropped", 32'(strobeCount - c0), 0);
    sendFrame({1'b1, 2'b10, val}, 19);
    repeat (4) @(negedge clk);
    check(strobeCount == c0 + 1 && strobeVal == val && !timeoutFlag,
          "R8 next frame accepted", 32'(strobeVal), 32'(val));
  endtask

  task automatic testResponderIgnores();
    int c0;
    useBench = 1'b1; modeResponder = 1'b1;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    quietTx(20, "R9 start ignored");
    c0 = strobeCount;
    sendFrame({1'b1, 2'b10, 16'h1234}, 19);
    repeat (4) @(negedge clk);
    check(strobeCount == c0, "R9 reply ignored", 32'(strobeCount - c0), 0);
    @(negedge clk);
    sendFrame(19'b111, 3);
    quietTx(20, "R8 no reply to bad type");
    modeResponder = 1'b0;
  endtask

  task automatic testRequesterIgnores();
    int c0;
    useBench = 1'b1; modeResponder = 1'b0;
    @(negedge clk);
    sendFrame(19'b101, 3);
    quietTx(50, "R10 request ignored");
    c0 = strobeCount;
    @(negedge clk);
    sendFrame({1'b1, 2'b10, 16'h5555}, 19);
    repeat (4) @(negedge clk);
    check(strobeCount == c0, "R5 idle reply ignored", 32'(strobeCount - c0), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRequestFrame();
    testEndToEnd();
    testTimeout();
    testBadType();
    testResponder();
    testResponderIgnores();
    testRequesterIgnores();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule